// File: doc/BRIEF.md
# Next-PC Selection and Control-Hazard Unit

This block computes the fetch address for a three-stage pipeline (fetch, execute, writeback) whose instruction memory is addressed by word. It holds the fetch program counter, the address of the instruction now in execute, and the execute-stage instruction register, which is loaded each cycle from the instruction memory read data. From the instruction in execute it forms the targets for conditional branches, jump-and-link and jump-and-link-register. It tells the external ALU which comparison to run for a branch, and it uses that ALU result to decide whether the branch is taken. It then selects the next fetch address.

Every redirect is computed relative to the address of the executing instruction. The instruction fetched behind a redirect has already been loaded into execute. It is cancelled by a one-cycle stall bit that travels with it. While that bit is set, the instruction cannot redirect and cannot produce a link write. The ALU, register file and instruction memory sit outside the block.

Top module: `pc_redirect_unit`

## Requirements
- R1: A synchronous active-high reset clears the fetch PC, the execute PC, the execute instruction register and the execute stall bit to zero. While these are zero, the PC source reads 2'b00.
- R2: With no redirect, the fetch PC advances by one each cycle. The execute PC takes the previous fetch PC, and the execute instruction register takes the memory read data presented in the previous cycle.
- R3: A taken conditional branch (opcode 7'h63) jumps to the execute PC plus the sign-extended word offset. The offset is bits [12:2] of the byte offset {instr[31], instr[7], instr[30:25], instr[11:8], 0}. The result wraps modulo 2^PC_W.
- R4: Jump-and-link (opcode 7'h6f) always redirects to the execute PC plus the sign-extended bits [20:2] of {instr[31], instr[19:12], instr[20], instr[30:21], 0}.
- R5: Jump-and-link-register (opcode 7'h67, funct3 000) redirects to rs1[PC_W+1:2] plus the sign-extended bits [11:2] of instr[31:20]. The two low bits of rs1 play no part.
- R6: For funct3 000 (equal) and 001 (not equal), the requested ALU op is SUB (4'b0100). Equal is taken when the result is zero, and not-equal is taken when it is nonzero.
- R7: For funct3 100 and 101 the requested op is SLT (4'b1100), and for 110 and 111 it is SLTU (4'b1101). Funct3 100 and 110 are taken when the result equals 1. Funct3 101 and 111 are taken when the result equals 0.
- R8: The PC source encodes sequential as 2'b00, branch as 2'b01, jump-and-link as 2'b10 and jump-and-link-register as 2'b11.
- R9: Any redirect raises stall_fetch in the same cycle, and stall_ex follows one cycle later. While stall_ex is high the PC source is 2'b00 and the fetch PC advances by one.
- R10: The link value is the fetch PC, zero-extended. link_write is high only for a jump-and-link or jump-and-link-register in execute while stall_ex is low.
- R11: Any other opcode, any branch funct3 of 010 or 011, and any jump-and-link-register funct3 other than 000 leave the PC source at 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_rdata | input | 32 | Instruction read at pc_fetch |
| alu_result | input | XLEN | ALU result for the instruction in execute |
| rs1_data | input | XLEN | First source register value for the instruction in execute |
| pc_fetch | output | PC_W | Fetch word address |
| pc_ex | output | PC_W | Word address of the instruction in execute |
| instr_ex | output | 32 | Instruction in execute |
| br_alu_op | output | 4 | ALU op needed to resolve the branch in execute |
| pc_src | output | 2 | Next-PC source select |
| stall_fetch | output | 1 | Redirect this cycle; the fetched instruction is wrong-path |
| stall_ex | output | 1 | The instruction in execute is cancelled |
| link_value | output | XLEN | Return address for jump-and-link |
| link_write | output | 1 | Write link_value to rd this cycle |

## Verification
The bench builds the block with PC_W = 8 and XLEN = 32. At that width the largest branch offsets and the jump offsets wrap the fetch address, so the modulo behaviour of every target adder is exercised. Jump-register bases larger than the address space show that the bits of rs1 above the PC width are discarded. The default 12-bit width is the one covered by elaboration alone.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [1:0] {
        PCS_SEQ  = 2'b00,
        PCS_BR   = 2'b01,
        PCS_JAL  = 2'b10,
        PCS_JALR = 2'b11
    } pc_src_e;

    typedef enum logic [1:0] {
        CND_ZERO    = 2'd0,
        CND_NONZERO = 2'd1,
        CND_ONE     = 2'd2
    } br_cond_e;

    localparam logic [3:0] ALU_SUB  = 4'b0100;
    localparam logic [3:0] ALU_SLT  = 4'b1100;
    localparam logic [3:0] ALU_SLTU = 4'b1101;

    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_JAL    = 7'h6f;
    localparam logic [6:0] OPC_JALR   = 7'h67;

    typedef struct packed {
        logic     is_branch;
        logic     is_jal;
        logic     is_jalr;
        br_cond_e cond;
        logic [3:0] alu_op;
    } flow_ctl_t;

    function automatic flow_ctl_t classify(input logic [6:0] opc, input logic [2:0] f3);
        flow_ctl_t c;
        c.is_branch = 1'b0;
        c.is_jal    = 1'b0;
        c.is_jalr   = 1'b0;
        c.cond      = CND_ZERO;
        c.alu_op    = ALU_SUB;
        case (opc)
            OPC_JAL:  c.is_jal  = 1'b1;
            OPC_JALR: c.is_jalr = (f3 == 3'b000);
            OPC_BRANCH: begin
                case (f3)
                    3'b000: begin c.is_branch = 1'b1; c.cond = CND_ZERO;    c.alu_op = ALU_SUB;  end
                    3'b001: begin c.is_branch = 1'b1; c.cond = CND_NONZERO; c.alu_op = ALU_SUB;  end
                    3'b100: begin c.is_branch = 1'b1; c.cond = CND_ONE;     c.alu_op = ALU_SLT;  end
                    3'b101: begin c.is_branch = 1'b1; c.cond = CND_ZERO;    c.alu_op = ALU_SLT;  end
                    3'b110: begin c.is_branch = 1'b1; c.cond = CND_ONE;     c.alu_op = ALU_SLTU; end
                    3'b111: begin c.is_branch = 1'b1; c.cond = CND_ZERO;    c.alu_op = ALU_SLTU; end
                    default: c.is_branch = 1'b0;
                endcase
            end
            default: c.is_branch = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [6:0]      opcode,
    input  logic [2:0]      funct3,
    input  logic            stall_ex,
    input  logic [XLEN-1:0] alu_result,
    output pc_src_e         pc_src,
    output logic [3:0]      alu_op,
    output logic            jump_live
);

    flow_ctl_t ctl;
    logic      res_zero;
    logic      res_one;
    logic      cond_met;

    always_comb begin
        ctl      = classify(opcode, funct3);
        res_zero = (alu_result == '0);
        res_one  = (alu_result == XLEN'(1));
        case (ctl.cond)
            CND_ZERO:    cond_met = res_zero;
            CND_NONZERO: cond_met = !res_zero;
            CND_ONE:     cond_met = res_one;
            default:     cond_met = 1'b0;
        endcase
    end

    always_comb begin
        if (stall_ex)                      pc_src = PCS_SEQ;
        else if (ctl.is_jal)               pc_src = PCS_JAL;
        else if (ctl.is_jalr)              pc_src = PCS_JALR;
        else if (ctl.is_branch && cond_met) pc_src = PCS_BR;
        else                               pc_src = PCS_SEQ;
    end

    assign alu_op    = ctl.alu_op;
    assign jump_live = !stall_ex && (ctl.is_jal || ctl.is_jalr);

endmodule

// File: rtl/flow_target.sv
module flow_target
    import flow_pkg::*;
#(
    parameter int PC_W = 12,
    parameter int XLEN = 32
) (
    input  logic [31:7]     instr_hi,
    input  logic [PC_W-1:0] pc_fetch,
    input  logic [PC_W-1:0] pc_ex,
    input  logic [XLEN-1:0] rs1_data,
    input  pc_src_e         pc_src,
    output logic [PC_W-1:0] next_pc
);

    localparam int BR_BITS  = 13;
    localparam int JAL_BITS = 21;

    logic [BR_BITS-1:0]  br_byte;
    logic [JAL_BITS-1:0] jal_byte;
    logic [11:0]         jr_imm;
    logic signed [31:0]  br_words;
    logic signed [31:0]  jal_words;
    logic signed [31:0]  jr_words;
    logic [PC_W-1:0]     br_tgt;
    logic [PC_W-1:0]     jal_tgt;
    logic [PC_W-1:0]     jr_tgt;
    logic                unused_rs1;

    always_comb begin
        br_byte  = {instr_hi[31], instr_hi[7], instr_hi[30:25], instr_hi[11:8], 1'b0};
        jal_byte = {instr_hi[31], instr_hi[19:12], instr_hi[20], instr_hi[30:21], 1'b0};
        jr_imm   = instr_hi[31:20];
        br_words  = 32'($signed(br_byte[BR_BITS-1:2]));
        jal_words = 32'($signed(jal_byte[JAL_BITS-1:2]));
        jr_words  = 32'($signed(jr_imm[11:2]));
        br_tgt  = pc_ex + br_words[PC_W-1:0];
        jal_tgt = pc_ex + jal_words[PC_W-1:0];
        jr_tgt  = rs1_data[PC_W+1:2] + jr_words[PC_W-1:0];
    end

    assign unused_rs1 = ^{rs1_data[XLEN-1:PC_W+2], rs1_data[1:0], br_byte[1:0], jal_byte[1:0], jr_imm[1:0]};

    always_comb begin
        case (pc_src)
            PCS_BR:   next_pc = br_tgt;
            PCS_JAL:  next_pc = jal_tgt;
            PCS_JALR: next_pc = jr_tgt;
            default:  next_pc = pc_fetch + PC_W'(1);
        endcase
    end

endmodule

// File: rtl/pc_redirect_unit.sv
module pc_redirect_unit
    import flow_pkg::*;
#(
    parameter int PC_W = 12,
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     imem_rdata,
    input  logic [XLEN-1:0] alu_result,
    input  logic [XLEN-1:0] rs1_data,
    output logic [PC_W-1:0] pc_fetch,
    output logic [PC_W-1:0] pc_ex,
    output logic [31:0]     instr_ex,
    output logic [3:0]      br_alu_op,
    output logic [1:0]      pc_src,
    output logic            stall_fetch,
    output logic            stall_ex,
    output logic [XLEN-1:0] link_value,
    output logic            link_write
);

    localparam int PAD_W = XLEN - PC_W;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pcex_q;
    logic [31:0]     instr_q;
    logic            stall_q;
    logic [PC_W-1:0] next_pc;
    pc_src_e         src;
    logic            jump_live;

    flow_decode #(.XLEN(XLEN)) u_decode (
        .opcode     (instr_q[6:0]),
        .funct3     (instr_q[14:12]),
        .stall_ex   (stall_q),
        .alu_result (alu_result),
        .pc_src     (src),
        .alu_op     (br_alu_op),
        .jump_live  (jump_live)
    );

    flow_target #(.PC_W(PC_W), .XLEN(XLEN)) u_target (
        .instr_hi (instr_q[31:7]),
        .pc_fetch (pc_q),
        .pc_ex    (pcex_q),
        .rs1_data (rs1_data),
        .pc_src   (src),
        .next_pc  (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            pcex_q  <= '0;
            instr_q <= '0;
            stall_q <= 1'b0;
        end else begin
            pc_q    <= next_pc;
            pcex_q  <= pc_q;
            instr_q <= imem_rdata;
            stall_q <= stall_fetch;
        end
    end

    assign pc_fetch    = pc_q;
    assign pc_ex       = pcex_q;
    assign instr_ex    = instr_q;
    assign stall_ex    = stall_q;
    assign pc_src      = src;
    assign stall_fetch = (src != PCS_SEQ);
    assign link_value  = {{PAD_W{1'b0}}, pc_q};
    assign link_write  = jump_live;

    AST_STALL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        stall_fetch |=> stall_ex);                                       // R9
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        stall_ex |-> !stall_fetch);                                      // R9
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !stall_fetch |=> pc_fetch == $past(pc_fetch) + PC_W'(1));        // R2
    AST_EX_PC_TRAILS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_ex == $past(pc_fetch));                              // R2
    AST_LINK_GATED: assert property (@(posedge clk) disable iff (rst)
        link_write |-> !stall_ex);                                       // R10
    AST_BR_NEEDS_OPCODE: assert property (@(posedge clk) disable iff (rst)
        pc_src == 2'b01 |-> instr_ex[6:0] == OPC_BRANCH);                // R8

endmodule

// File: tb/pc_redirect_unit_bench.sv
`timescale 1ns/1ps
module pc_redirect_unit_bench;

    localparam int PC_W = 8;
    localparam int XLEN = 32;
    localparam int NV   = 18;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     imem_rdata = NOP;
    logic [XLEN-1:0] alu_result = '0;
    logic [XLEN-1:0] rs1_data = '0;
    logic [PC_W-1:0] pc_fetch, pc_ex;
    logic [31:0]     instr_ex;
    logic [3:0]      br_alu_op;
    logic [1:0]      pc_src;
    logic            stall_fetch, stall_ex, link_write;
    logic [XLEN-1:0] link_value;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pc_redirect_unit #(.PC_W(PC_W), .XLEN(XLEN)) u_pc_redirect_unit (
        .clk, .rst, .imem_rdata, .alu_result, .rs1_data, .pc_fetch, .pc_ex,
        .instr_ex, .br_alu_op, .pc_src, .stall_fetch, .stall_ex,
        .link_value, .link_write
    );

    // kind: 0 branch, 1 jal, 2 jalr, 3 other opcode
    localparam int          V_KIND [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1,1,2,2,3,0};
    localparam logic [2:0]  V_F3   [NV] = '{0,0,1,1,4,5,5,4,6,7,7,2,0,0,0,0,0,3};
    localparam int          V_OFF  [NV] = '{16,16,-8,-8,40,-20,-20,8,4092,-4096,12,8,
                                            -12,2048,-8,12,0,8};
    localparam logic [31:0] V_ALU  [NV] = '{0,5,5,0,1,0,1,0,1,0,1,0,0,0,0,0,0,0};
    localparam logic [31:0] V_RS1  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,32'h100,32'h7F3,0,0};
    localparam logic [1:0]  V_SEL  [NV] = '{1,0,1,0,1,1,0,0,1,1,0,0,2,2,3,3,0,0};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_b(input int off, input logic [2:0] f3);
        logic [12:0] b;
        b = off[12:0];
        return {b[12], b[10:5], 5'd2, 5'd1, f3, b[4:1], b[11], 7'h63};
    endfunction

    function automatic logic [31:0] enc_j(input int off);
        logic [20:0] j;
        j = off[20:0];
        return {j[20], j[10:1], j[11], j[19:12], 5'd1, 7'h6f};
    endfunction

    function automatic logic [31:0] enc_jr(input int off);
        logic [11:0] m;
        m = off[11:0];
        return {m, 5'd3, 3'b000, 5'd1, 7'h67};
    endfunction

    function automatic logic [3:0] exp_op(input logic [2:0] f3);
        case (f3)
            3'd0, 3'd1: return 4'b0100;
            3'd4, 3'd5: return 4'b1100;
            default:    return 4'b1101;
        endcase
    endfunction

    task automatic run_vec(input int i);
        logic [31:0] ins;
        logic [PC_W-1:0] p;
        int exp_next;
        string tag;
        case (V_KIND[i])
            0: begin ins = enc_b(V_OFF[i], V_F3[i]); tag = (V_F3[i] < 2) ? "R6" : "R7"; end
            1: begin ins = enc_j(V_OFF[i]); tag = "R4"; end
            2: begin ins = enc_jr(V_OFF[i]); tag = "R5"; end
            default: begin ins = 32'h0020_80B3; tag = "R11"; end
        endcase
        if (V_KIND[i] == 0 && (V_F3[i] == 2 || V_F3[i] == 3)) tag = "R11";
        imem_rdata = NOP; tick(); tick();
        p = pc_fetch;
        imem_rdata = ins;
        tick();
        check("R2", "pc_ex", pc_ex, p);
        imem_rdata = NOP;
        alu_result = V_ALU[i];
        rs1_data   = V_RS1[i];
        #1;
        check(tag, "pc_src", pc_src, V_SEL[i]);
        check("R8", "stall_fetch", stall_fetch, V_SEL[i] != 2'b00);
        if (V_KIND[i] == 0 && V_F3[i] != 2 && V_F3[i] != 3)
            check(tag, "br_alu_op", br_alu_op, exp_op(V_F3[i]));
        check("R10", "link_write", link_write, V_KIND[i] == 1 || V_KIND[i] == 2);
        check("R10", "link_value", link_value, 32'(p) + 1);
        case (V_SEL[i])
            2'b01, 2'b10: exp_next = int'(p) + (V_OFF[i] >>> 2);
            2'b11:        exp_next = int'(V_RS1[i] >> 2) + (V_OFF[i] >>> 2);
            default:      exp_next = int'(p) + 2;
        endcase
        tick();
        check(V_SEL[i] == 2'b01 ? "R3" : tag, "pc_fetch", pc_fetch, exp_next & 8'hFF);
        check("R9", "stall_ex", stall_ex, V_SEL[i] != 2'b00);
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] q;
        tick(); tick();
        check("R1", "pc_fetch", pc_fetch, 0);
        check("R1", "pc_ex", pc_ex, 0);
        check("R1", "instr_ex", instr_ex, 0);
        check("R1", "stall_ex", stall_ex, 0);
        check("R1", "pc_src", pc_src, 0);
        #1 rst = 1'b0;

        // R2 sequential flow
        for (int k = 1; k <= 4; k++) begin
            imem_rdata = 32'h0000_0033 | (32'(k) << 20);
            tick();
            check("R2", "pc_fetch", pc_fetch, k);
            check("R2", "pc_ex", pc_ex, k - 1);
            check("R2", "instr_ex", instr_ex, 32'h0000_0033 | (32'(k) << 20));
        end

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: wrong-path jump in the shadow is cancelled
        imem_rdata = NOP; tick(); tick();
        imem_rdata = enc_j(8);
        tick();
        imem_rdata = enc_j(-40);
        #1;
        check("R9", "pc_src first jump", pc_src, 2'b10);
        tick();
        imem_rdata = NOP;
        #1;
        check("R9", "stall_ex", stall_ex, 1);
        check("R9", "pc_src shadow", pc_src, 2'b00);
        check("R10", "link_write shadow", link_write, 0);
        check("R9", "stall_fetch shadow", stall_fetch, 0);
        q = pc_fetch;
        tick();
        check("R9", "pc after shadow", pc_fetch, q + 8'd1);
        check("R9", "stall_ex clear", stall_ex, 0);

        // R1 reset mid-run
        imem_rdata = enc_j(16);
        tick();
        rst = 1'b1;
        tick();
        check("R1", "pc_fetch", pc_fetch, 0);
        check("R1", "pc_ex", pc_ex, 0);
        check("R1", "instr_ex", instr_ex, 0);
        check("R1", "stall_ex", stall_ex, 0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule